// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port reached through a plain register bus (address, write enable, write data, read enable, read data). Software sets each pin as input or output, writes the value driven on output pins, and reads the synchronized level of every pin. Each pin can also raise an interrupt on one of four conditions: low level, high level, rising edge or falling edge.

Pin inputs pass through a two-stage synchronizer. A per-pin trigger field selects the condition, and a sticky status register records events until software clears them by writing ones. A mask register decides which status bits reach the two interrupt outputs: one covers pins 0 to 15, the other pins 16 to 31. Level-mode events re-assert every cycle while the level holds, so a clear only sticks once the level goes away.

Top module: `gpio_irq_port`

## Requirements
- R1: A write to offset 0x00 stores the word in the output data register, which drives `pinOut` from the next cycle and reads back unchanged at offset 0x00; reads at offsets with nonzero low two bits or above 0x18 return 0.
- R2: Offset 0x04 is the direction register: bit value 1 makes the pin an output, 0 an input; `pinOutEn` equals this register from the cycle after the write and it reads back unchanged.
- R3: Offset 0x08 reads the pin levels after a two-flop synchronizer: a level applied to `pinIn` is returned two clock edges later; writes to this offset have no effect.
- R4: Offset 0x0C holds the 2-bit trigger fields of pins 0 to 15 (pin n at bits 2n+1:2n) and offset 0x10 those of pins 16 to 31 (pin n at bits 2(n-16)+1:2(n-16)); both read back as written; encoding 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R5: In edge modes (10 rising, 11 falling) a status bit sets on the synchronized transition, three clock edges after the pin changes, and stays clear after being cleared while the pin holds still.
- R6: In level modes (00 low, 01 high) the status bit is set every cycle the synchronized level matches, so a clear issued while the level holds leaves the bit set; a set in the same cycle as a clear wins.
- R7: Offset 0x18 is the status register; writing 1 to a bit clears it, writing 0 leaves it unchanged, and status bits persist after the pin condition ends.
- R8: Offset 0x14 is the mask register (1 enables a pin); an interrupt output is high only when status AND mask is nonzero in its half.
- R9: `irqLow` reflects masked status bits 15:0 and `irqHigh` bits 31:16, independently of each other.
- R10: During and right after reset, data, direction, mask, both trigger registers and status read 0, `pinOut` and `pinOutEn` are 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte offset of the register accessed |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read enable; read data is combinational |
| busRdData | output | 32 | Read data, 0 when not reading |
| pinIn | input | 32 | Asynchronous pin input levels |
| pinOut | output | 32 | Output data driven to the pads |
| pinOutEn | output | 32 | Per-pin output enable |
| irqLow | output | 1 | Interrupt for pins 0 to 15 |
| irqHigh | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The hardest situation to reach from the ports is the race between a status clear and a level event still in force, together with the sticky status that remains after a level condition ends. The stimulus walks each of the four trigger modes through a fixed sequence of pin high, clear, pin low on randomly chosen pins, reading the status word after every step, so the level modes show a clear that fails to stick while edge modes show a clear that holds. Directed steps then place events in both halves with partial masks to separate the two interrupt outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_PAD   = 3'd2,
    SEL_CFGLO = 3'd3,
    SEL_CFGHI = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrClr;
    logic    rdEn;
    regSel_e rdSel;
  } portStrobes_t;

  localparam logic [1:0] TRIG_LOW  = 2'b00;
  localparam logic [1:0] TRIG_HIGH = 2'b01;
  localparam logic [1:0] TRIG_RISE = 2'b10;
  localparam logic [1:0] TRIG_FALL = 2'b11;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output portStrobes_t      strobes
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  regSel_e          sel;

  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (busAddr[1:0] == 2'b00 && wordIdx < IDX_W'(7)) begin
      sel = regSel_e'(wordIdx[2:0]);
    end
  end

  always_comb begin
    strobes.wrData  = busWrEn && (sel == SEL_DATA);
    strobes.wrDir   = busWrEn && (sel == SEL_DIR);
    strobes.wrCfgLo = busWrEn && (sel == SEL_CFGLO);
    strobes.wrCfgHi = busWrEn && (sel == SEL_CFGHI);
    strobes.wrMask  = busWrEn && (sel == SEL_MASK);
    strobes.wrClr   = busWrEn && (sel == SEL_STAT);
    strobes.rdEn    = busRdEn;
    strobes.rdSel   = sel;
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqLow,
  output logic                irqHigh,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] maskQ
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ;
  logic [NUM_PINS-1:0] syncA, syncB, prevQ;
  logic [NUM_PINS-1:0] setEvt, clrBits, maskedStat;

  // configuration and output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobes.wrData)  dataQ  <= wrData;
      if (strobes.wrDir)   dirQ   <= wrData;
      if (strobes.wrCfgLo) cfgLoQ <= wrData;
      if (strobes.wrCfgHi) cfgHiQ <= wrData;
      if (strobes.wrMask)  maskQ  <= wrData;
    end
  end

  // two-stage synchronizer plus previous sample for edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  // per-pin trigger decode
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_trig
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = cfgLoQ[2*p +: 2];
    end else begin : g_hi
      assign mode = cfgHiQ[2*(p-HALF) +: 2];
    end
    assign setEvt[p] = ((mode == TRIG_LOW)  && !syncB[p]) ||
                       ((mode == TRIG_HIGH) &&  syncB[p]) ||
                       ((mode == TRIG_RISE) &&  syncB[p] && !prevQ[p]) ||
                       ((mode == TRIG_FALL) && !syncB[p] &&  prevQ[p]);
  end

  assign clrBits = strobes.wrClr ? wrData : '0;

  // sticky status, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrBits) | setEvt;
    end
  end

  assign maskedStat = statusQ & maskQ;
  assign irqLow     = |maskedStat[HALF-1:0];
  assign irqHigh    = |maskedStat[NUM_PINS-1:HALF];
  assign pinOut     = dataQ;
  assign pinOutEn   = dirQ;

  always_comb begin
    rdData = '0;
    if (strobes.rdEn) begin
      case (strobes.rdSel)
        SEL_DATA:  rdData = dataQ;
        SEL_DIR:   rdData = dirQ;
        SEL_PAD:   rdData = syncB;
        SEL_CFGLO: rdData = cfgLoQ;
        SEL_CFGHI: rdData = cfgHiQ;
        SEL_MASK:  rdData = maskQ;
        SEL_STAT:  rdData = statusQ;
        default:   rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] busWrData,
  input  logic                busRdEn,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqLow,
  output logic                irqHigh
);

  portStrobes_t        strobes;
  logic [NUM_PINS-1:0] statusQ;
  logic [NUM_PINS-1:0] maskQ;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  gpio_port_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (busWrData),
    .pinIn    (pinIn),
    .rdData   (busRdData),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh),
    .statusQ  (statusQ),
    .maskQ    (maskQ)
  );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [NUM_PINS-1:0] busWrData,
  input logic                busRdEn,
  input logic [NUM_PINS-1:0] busRdData,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOutEn,
  input logic                irqLow,
  input logic                irqHigh,
  input logic [NUM_PINS-1:0] statusQ,
  input logic [NUM_PINS-1:0] maskQ
);

  logic [1:0]          upCnt;
  logic [NUM_PINS-1:0] clrSeen;

  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assign clrSeen = (busWrEn && busAddr == ADDR_W'(24)) ? busWrData : '0;

  // R1
  data_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(0)) |=> (pinOut == $past(busWrData)));

  // R2
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(4)) |=> (pinOutEn == $past(busWrData)));

  // R3
  pad_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && busRdEn && busAddr == ADDR_W'(8)) |-> (busRdData == $past(pinIn, 2)));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((($past(statusQ) & ~statusQ)) & ~$past(clrSeen)) == '0));

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> (!irqLow && !irqHigh));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;

  localparam int NP = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
    A_CFGLO = 5'h0C, A_CFGHI = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] busAddr;
  logic          busWrEn;
  logic [NP-1:0] busWrData;
  logic          busRdEn;
  logic [NP-1:0] busRdData;
  logic [NP-1:0] pinIn;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOutEn;
  logic          irqLow;
  logic          irqHigh;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [NP-1:0] cfgLo, cfgHi;

  always #2 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [NP-1:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(int pin, logic [1:0] mode);
    if (pin < 16) begin
      cfgLo[2*pin +: 2] = mode;
      wr(A_CFGLO, cfgLo);
    end else begin
      cfgHi[2*(pin-16) +: 2] = mode;
      wr(A_CFGHI, cfgHi);
    end
  endtask

  // expected status bit for the walk: phase 0 after pin high,
  // 1 after clear with pin high, 2 after pin low again
  function automatic bit walkExp(logic [1:0] mode, int phase);
    case (mode)
      2'b00:   return (phase != 1);
      2'b01:   return 1'b1;
      2'b10:   return (phase == 0);
      default: return (phase == 2);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] v, d;
    void'($urandom(32'd1357));
    rstN = 1'b0; busAddr = '0; busWrEn = 0; busWrData = '0; busRdEn = 0; pinIn = '0;
    waitCyc(3);
    // R10 reset state
    rd(A_DATA, d);  check("R10 data", d, '0);
    rd(A_DIR, d);   check("R10 dir", d, '0);
    rd(A_CFGLO, d); check("R10 cfgLo", d, '0);
    rd(A_CFGHI, d); check("R10 cfgHi", d, '0);
    rd(A_MASK, d);  check("R10 mask", d, '0);
    rd(A_STAT, d);  check("R10 status", d, '0);
    check("R10 pinOut", pinOut, '0);
    check("R10 pinOutEn", pinOutEn, '0);
    check("R10 irq", {30'd0, irqHigh, irqLow}, '0);
    rstN = 1'b1;

    cfgLo = 32'h5555_5555; cfgHi = 32'h5555_5555;
    wr(A_CFGLO, cfgLo); wr(A_CFGHI, cfgHi);
    rd(A_CFGLO, d); check("R4 cfgLo readback", d, cfgLo);
    wr(A_STAT, '1);
    rd(A_STAT, d); check("R7 clear all", d, '0);
    rd(5'h1C, d); check("R1 unmapped read", d, '0);
    rd(5'h05, d); check("R1 unaligned read", d, '0);

    // random register traffic
    for (int i = 0; i < 40; i++) begin
      int sel;
      v = $urandom();
      sel = $urandom_range(0, 2);
      if (sel == 0) begin
        wr(A_DATA, v); rd(A_DATA, d);
        check("R1 data readback", d, v); check("R1 pinOut", pinOut, v);
      end else if (sel == 1) begin
        wr(A_DIR, v); rd(A_DIR, d);
        check("R2 dir readback", d, v); check("R2 pinOutEn", pinOutEn, v);
      end else begin
        wr(A_MASK, v); rd(A_MASK, d); check("R8 mask readback", d, v);
        check("R8 irq idle", {30'd0, irqHigh, irqLow}, '0);
      end
    end
    v = $urandom(); wr(A_CFGHI, v); rd(A_CFGHI, d); check("R4 cfgHi readback", d, v);
    wr(A_CFGHI, cfgHi);
    wr(A_MASK, '0);

    // R3 pad status with two-edge latency
    for (int i = 0; i < 10; i++) begin
      v = $urandom();
      @(negedge clk); pinIn = v;
      waitCyc(2);
      rd(A_PAD, d); check("R3 pad level", d, v);
    end
    wr(A_PAD, 32'hFFFF_0000);
    rd(A_PAD, d); check("R3 pad write ignored", d, v);
    @(negedge clk); pinIn = '0;
    waitCyc(3); wr(A_STAT, '1);
    rd(A_STAT, d); check("R7 clear after pad test", d, '0);

    // R5 rising edge pin 3
    setMode(3, 2'b10);
    @(negedge clk); pinIn[3] = 1'b1;
    waitCyc(3);
    rd(A_STAT, d); check("R5 rise sets", d, 32'h0000_0008);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, d); check("R5 rise clear sticks", d, '0);
    @(negedge clk); pinIn[3] = 1'b0;
    waitCyc(3);
    rd(A_STAT, d); check("R5 rise ignores fall", d, '0);

    // R5 falling edge pin 20
    setMode(20, 2'b11);
    @(negedge clk); pinIn[20] = 1'b1;
    waitCyc(3);
    rd(A_STAT, d); check("R5 fall ignores rise", d, '0);
    @(negedge clk); pinIn[20] = 1'b0;
    waitCyc(3);
    rd(A_STAT, d); check("R5 fall sets", d, 32'h0010_0000);
    wr(A_STAT, 32'h0010_0000);

    // R6 high level pin 7, R7 write zero
    @(negedge clk); pinIn[7] = 1'b1;
    waitCyc(3);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, d); check("R6 high level clear does not stick", d, 32'h0000_0080);
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, d); check("R7 write zero keeps", d, 32'h0000_0080);
    @(negedge clk); pinIn[7] = 1'b0;
    waitCyc(3);
    rd(A_STAT, d); check("R7 status persists", d, 32'h0000_0080);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, d); check("R7 clear after level gone", d, '0);

    // R6 low level pin 25
    setMode(25, 2'b00);
    wr(A_STAT, 32'h0200_0000);
    rd(A_STAT, d); check("R6 low level re-sets", d, 32'h0200_0000);
    @(negedge clk); pinIn[25] = 1'b1;
    waitCyc(3);
    wr(A_STAT, 32'h0200_0000);
    rd(A_STAT, d); check("R6 low level cleared when high", d, '0);
    @(negedge clk); pinIn[25] = 1'b0;
    setMode(25, 2'b01); wr(A_STAT, '1);

    // R8 and R9 mask and halves
    @(negedge clk); pinIn[5] = 1'b1;
    waitCyc(3);
    #1 check("R8 masked off", {30'd0, irqHigh, irqLow}, '0);
    wr(A_MASK, 32'h0000_0020);
    #1 check("R9 low half only", {30'd0, irqHigh, irqLow}, 32'd1);
    @(negedge clk); pinIn[18] = 1'b1;
    waitCyc(3);
    #1 check("R9 high unmasked stays low", {30'd0, irqHigh, irqLow}, 32'd1);
    wr(A_MASK, 32'h0004_0000);
    #1 check("R9 high half only", {30'd0, irqHigh, irqLow}, 32'd2);
    @(negedge clk); pinIn = '0;
    waitCyc(3); wr(A_STAT, '1);
    #1 check("R8 cleared irq drops", {30'd0, irqHigh, irqLow}, '0);
    wr(A_MASK, '0);

    // random mode walks
    for (int i = 0; i < 30; i++) begin
      int pin;
      logic [1:0] mode;
      logic [NP-1:0] bitv;
      pin = $urandom_range(0, NP-1);
      mode = 2'($urandom_range(0, 3));
      bitv = 32'd1 << pin;
      setMode(pin, mode);
      waitCyc(3);
      wr(A_STAT, '1);
      @(negedge clk); pinIn[pin] = 1'b1;
      waitCyc(3);
      rd(A_STAT, d);
      check(mode[1] ? "R5 walk after high" : "R6 walk after high", d, walkExp(mode, 0) ? bitv : '0);
      wr(A_STAT, '1);
      rd(A_STAT, d);
      check(mode[1] ? "R5 walk after clear" : "R6 walk after clear", d, walkExp(mode, 1) ? bitv : '0);
      @(negedge clk); pinIn[pin] = 1'b0;
      waitCyc(3);
      rd(A_STAT, d);
      check(mode[1] ? "R5 walk after low" : "R6 walk after low", d, walkExp(mode, 2) ? bitv : '0);
      wr(A_MASK, bitv);
      #1 check("R9 walk irq", {30'd0, irqHigh, irqLow},
               walkExp(mode, 2) ? ((pin < 16) ? 32'd1 : 32'd2) : 32'd0);
      wr(A_MASK, '0);
      setMode(pin, 2'b01);
      wr(A_STAT, '1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule